// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block produces the two timing strobes a serial port needs: a bit-sample enable for the receiver's oversampling logic and a slower baud enable for the shift registers. Each strobe is a one-cycle pulse on the system clock. The source events come either from every clock cycle or from a divide-by-8 prescaler, chosen by a mode input. A 16-bit sample divisor sets how many source events make one sample tick. An 8-bit baud divisor then sets how many sample ticks make one baud tick, and one is added to its stored value, so the overall ratio is sample divisor times (baud divisor + 1).

Both divisors are written through a single write port, and a select bit picks the target register. A sample divisor of zero stops both strobes. A baud divisor write whose low byte is below four is dropped, with no effect at all. Every accepted write clears the prescaler, both counters and both strobes, so the new rate starts from a known phase.

Top module: `baud_tick_gen`

## Requirements
- R1: With sample divisor N ≥ 1, `sample_tick` repeats every N × P clock cycles, where P is the prescale ratio.
- R2: With baud divisor B, `baud_tick` repeats every N × (B + 1) × P clock cycles.
- R3: `presc_sel` = 0 gives P = 1, so every cycle is a source event; `presc_sel` = 1 gives P = 8.
- R4: Each strobe is high for exactly one cycle. The only exception is N = 1 with P = 1, where `sample_tick` stays high.
- R5: After reset the sample divisor is 651 (0x28B) and the baud divisor is 15. With P = 1 this gives a sample period of 651 cycles and a baud period of 10416 cycles.
- R6: A baud divisor write uses only `wr_data[7:0]`. If that value is below 4, the write is ignored: the divisor is kept, the counters are not cleared and the tick phase is unchanged. A value of 4 or more is accepted.
- R7: A sample divisor of 0 stops both `sample_tick` and `baud_tick`.
- R8: An accepted write clears all counters. The first `sample_tick` is then high after the N × P-th rising edge following the write edge. The first `baud_tick` is high after the ((B + 1) × N × P + 1)-th rising edge.
- R9: `wr_sel` = 0 writes the 16-bit sample divisor from `wr_data`; `wr_sel` = 1 writes the baud divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor write strobe |
| wr_sel | input | 1 | 0 = sample divisor, 1 = baud divisor |
| wr_data | input | 16 | Write value |
| presc_sel | input | 1 | 1 = divide source by 8 |
| sample_tick | output | 1 | Bit-sample enable pulse |
| baud_tick | output | 1 | Baud enable pulse |

## Verification
The hardest case to reach is a rejected baud divisor write. It is only visible if nothing happens, so the stimulus has to show that the tick phase survived, not only that the rate did. The bench first locks onto a baud tick, then issues the illegal write, and then measures the partial interval up to the next tick. That interval must equal the full period minus the cycles the write took. An accepted write, by contrast, would restart the counters and give the longer restart latency.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  // Accept a baud divisor only at or above the legal floor.
  function automatic logic bdiv_legal(input int unsigned value, input int unsigned floor_v);
    return value >= floor_v;
  endfunction

  // Clock cycles per source event for a prescale choice.
  function automatic int unsigned src_ratio(input logic sel, input int unsigned ratio);
    return sel ? ratio : 1;
  endfunction

  // Cycles between baud ticks for given divisors.
  function automatic int unsigned baud_cycles(input int unsigned sdiv, input int unsigned bdiv,
                                              input int unsigned ratio);
    return sdiv * (bdiv + 1) * ratio;
  endfunction
endpackage

// File: rtl/bgen_regs.sv
module bgen_regs #(
  parameter int unsigned SDIV_W   = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter int unsigned BDIV_MIN = 4,
  parameter logic [SDIV_W-1:0] SDIV_RST = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [SDIV_W-1:0] wr_data,
  output logic [SDIV_W-1:0] sdiv_q,
  output logic [BDIV_W-1:0] bdiv_q,
  output logic              restart
);
  logic [BDIV_W-1:0] bdiv_in;
  logic bdiv_ok;
  logic wr_sample;
  logic wr_baud;

  assign bdiv_in   = wr_data[BDIV_W-1:0];
  assign bdiv_ok   = bgen_pkg::bdiv_legal(32'(bdiv_in), BDIV_MIN);
  assign wr_sample = wr_en && !wr_sel;
  assign wr_baud   = wr_en && wr_sel && bdiv_ok;
  assign restart   = wr_sample || wr_baud;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdiv_q <= SDIV_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      if (wr_sample) sdiv_q <= wr_data;
      if (wr_baud)   bdiv_q <= bdiv_in;
    end
  end

  // R6: an illegal baud divisor write leaves the stored value untouched
  a_r6_reject_small: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && (wr_data[BDIV_W-1:0] < BDIV_W'(BDIV_MIN))) |=> $stable(bdiv_q));
  // R6: stored baud divisor never falls below the floor
  a_r6_bdiv_floor: assert property (@(posedge clk) disable iff (!rst_n)
    bdiv_q >= BDIV_W'(BDIV_MIN));
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic presc_sel,
  output logic src_en
);
  generate
    if (RATIO <= 1) begin : g_bypass
      assign src_en = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(RATIO);
      logic [PW-1:0] pc;
      logic wrap;
      assign wrap = (pc == PW'(RATIO - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc <= '0;
        else if (clr)    pc <= '0;
        else if (wrap)   pc <= '0;
        else             pc <= pc + 1'b1;
      end
      assign src_en = presc_sel ? wrap : 1'b1;

      // R3: with prescale on, a source event is never followed by another next cycle
      a_r3_presc_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel && wrap && !clr) |=> !wrap);
    end
  endgenerate
endmodule

// File: rtl/bgen_counter.sv
module bgen_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic at_end;

  assign at_end = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step && run) begin
        if (at_end) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: pulse lasts one cycle unless the terminal value is zero
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> !tick);
  // counter never passes its terminal value while running
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && $stable(last)) |-> cnt <= last);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned SDIV_W      = 16,
  parameter int unsigned BDIV_W      = 8,
  parameter int unsigned BDIV_MIN    = 4,
  parameter int unsigned PRESC_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [SDIV_W-1:0] wr_data,
  input  logic              presc_sel,
  output logic              sample_tick,
  output logic              baud_tick
);
  logic [SDIV_W-1:0] sdiv_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic              restart;
  logic              src_en;
  logic              sample_run;
  logic [SDIV_W-1:0] sample_last;

  bgen_regs #(
    .SDIV_W(SDIV_W), .BDIV_W(BDIV_W), .BDIV_MIN(BDIV_MIN),
    .SDIV_RST(SDIV_W'(16'h028B)), .BDIV_RST(BDIV_W'(8'h0F))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sdiv_q(sdiv_q), .bdiv_q(bdiv_q), .restart(restart)
  );

  bgen_prescale #(.RATIO(PRESC_RATIO)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(restart), .presc_sel(presc_sel), .src_en(src_en)
  );

  assign sample_run  = (sdiv_q != '0);
  assign sample_last = sdiv_q - 1'b1;

  bgen_counter #(.W(SDIV_W)) u_sample (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(src_en), .run(sample_run),
    .last(sample_last), .tick(sample_tick)
  );

  bgen_counter #(.W(BDIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(sample_tick), .run(1'b1),
    .last(bdiv_q), .tick(baud_tick)
  );

  // R7: a zero sample divisor keeps both strobes low
  a_r7_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (sdiv_q == '0) |=> (!sample_tick && !baud_tick));
  // R8: an accepted write clears both strobes on the next cycle
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_tick && !baud_tick));
  // R2: a baud tick always follows a sample tick
  a_r2_baud_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(sample_tick));
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic presc_sel = 1'b0;
  logic sample_tick;
  logic baud_tick;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .presc_sel(presc_sel), .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  // stimulus table: prescale, sample divisor, baud divisor, expected periods
  localparam int NV = 4;
  localparam int V_PRE [NV] = '{0, 0, 1, 0};
  localparam int V_SD  [NV] = '{3, 5, 2, 1};
  localparam int V_BD  [NV] = '{4, 9, 5, 255};
  localparam int V_SP  [NV] = '{3, 5, 16, 1};
  localparam int V_BP  [NV] = '{15, 50, 96, 256};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input bit sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycles until chosen tick seen at a negedge; -1 if not within limit
  task automatic wait_tick(input bit is_baud, input int limit, output int n);
    bit seen;
    n = 0;
    seen = 1'b0;
    do begin
      @(negedge clk);
      n++;
      seen = is_baud ? baud_tick : sample_tick;
    end while (!seen && n < limit);
    if (!seen) n = -1;
  endtask

  initial begin
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset sample low", int'(sample_tick), 0);
    chk("R5 reset baud low", int'(baud_tick), 0);
    wait_tick(0, 2000, n);
    wait_tick(0, 2000, n);
    chk("R5 reset sample period", n, 651);
    wait_tick(1, 20000, n);
    wait_tick(1, 20000, n);
    chk("R5 reset baud period", n, 10416);

    // R8 restart latency, R9 select encoding
    write_reg(1, 6);
    write_reg(0, 4);
    wait_tick(1, 500, n);
    chk("R8 first baud latency", n, 29);
    wait_tick(1, 500, n);
    chk("R9 baud period sd4 bd6", n, 28);

    // R6 rejected write keeps phase: write spans two negedges after the tick
    write_reg(1, 16'h0003);
    wait_tick(1, 500, n);
    chk("R6 ignored write keeps phase", n, 26);
    wait_tick(1, 500, n);
    chk("R6 ignored write keeps rate", n, 28);
    write_reg(1, 16'hFF05);
    wait_tick(1, 500, n);
    chk("R6 upper byte ignored latency", n, 25);
    wait_tick(1, 500, n);
    chk("R6 upper byte ignored period", n, 24);
    write_reg(1, 4);
    wait_tick(1, 500, n);
    wait_tick(1, 500, n);
    chk("R6 floor value accepted", n, 20);

    // R4 single-cycle pulses
    write_reg(0, 3);
    wait_tick(0, 100, n);
    @(negedge clk);
    chk("R4 sample pulse width", int'(sample_tick), 0);
    wait_tick(1, 100, n);
    @(negedge clk);
    chk("R4 baud pulse width", int'(baud_tick), 0);

    // R7 zero divisor stops both strobes
    write_reg(0, 0);
    wait_tick(0, 200, n);
    chk("R7 sample stopped", n, -1);
    wait_tick(1, 200, n);
    chk("R7 baud stopped", n, -1);

    // table walk: R1, R2, R3, R8
    for (int i = 0; i < NV; i++) begin
      presc_sel = V_PRE[i][0];
      write_reg(1, V_BD[i]);
      write_reg(0, V_SD[i]);
      wait_tick(0, 1000, n);
      chk("R8 first sample latency", n, V_SP[i]);
      wait_tick(0, 1000, n);
      chk(V_PRE[i] != 0 ? "R3 prescaled sample period" : "R1 sample period", n, V_SP[i]);
      wait_tick(1, 2000, n);
      wait_tick(1, 2000, n);
      chk("R2 baud period", n, V_BP[i]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule